// File: doc/BRIEF.md
# DRAM Command Timing Gate

This block sits beside a DRAM command scheduler and answers one question every cycle: may the command being proposed right now go out to the memory without breaking a timing rule? It holds two programmable timing words, tracks which of the banks hold an open row, and keeps one countdown for each spacing rule. Each rule is tracked per bank where it applies to a single bank, and globally where it spans all banks. The scheduler presents a command code and a bank index. The block answers with `cmd_allowed` in the same cycle. A proposal is taken as issued when `prop_valid` and `cmd_allowed` are both high at a rising edge, and the block updates its state from that issue.

A second function keeps the refresh cadence. An interval counter counts down from the programmed refresh interval. When it runs out, the counter raises `refresh_req` and holds it until an AUTO-REFRESH issues. That issue reloads the counter. Every spacing count is in controller clock cycles. A timing value is sampled at the moment its countdown starts, so reprogramming a word changes only countdowns that start later.

Top module: `dram_cmd_timing_gate`

## Requirements
- R1: After reset, the interval word (`cfg_sel`=0) reads 0x0000040E and the row word (`cfg_sel`=1) reads 0x0F233286. The row word packs rfc[31:24], rrd[23:20], rp[19:16], rcd[15:12], rc[11:6] and ras[5:0]. The interval field is bits [15:0] of its word; bits [31:16] of that word read as zero whatever is written there.
- R2: `refresh_req` becomes 1 after exactly t_refi rising edges, counted from reset release or from the edge that issues AUTO-REFRESH. That edge itself is not counted.
- R3: `refresh_req` stays 1 until an AUTO-REFRESH issues, and it is 0 in the cycle after that issue.
- R4: A write to either timing word does not change a countdown that is already running; only countdowns started after the write use the new value.
- R5: Each bank is either open or closed. ACTIVATE is allowed only to a closed bank. READ, WRITE and PRECHARGE are allowed only to an open bank. An issued ACTIVATE opens the bank and an issued PRECHARGE closes it.
- R6: READ and WRITE to a bank are blocked until t_rcd cycles after that bank's ACTIVATE.
- R7: PRECHARGE to a bank is blocked until t_ras cycles after that bank's ACTIVATE. A second ACTIVATE to the same bank is blocked until t_rc cycles after the first.
- R8: ACTIVATE to a bank is blocked until t_rp cycles after that bank's PRECHARGE.
- R9: ACTIVATE to a bank other than the last activated one is blocked until t_rrd cycles after the last ACTIVATE.
- R10: AUTO-REFRESH requires every bank to be closed. After an AUTO-REFRESH, both ACTIVATE and AUTO-REFRESH are blocked for t_rfc cycles.
- R11: A row-word field programmed to zero gives the same one-cycle minimum spacing as a value of one.
- R12: Command codes on `prop_cmd` are: 0 no-op, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO-REFRESH. `cmd_allowed` is 0 for a no-op and for codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the timing word picked by `cfg_sel` |
| cfg_sel | input | 1 | 0 picks the refresh-interval word, 1 picks the row-timing word |
| cfg_wdata | input | DW (32) | Write data |
| cfg_rdata | output | DW (32) | Read data of the picked word, combinational |
| prop_valid | input | 1 | The proposal issues when this is high and `cmd_allowed` is high |
| prop_cmd | input | 3 | Proposed command code (see R12) |
| prop_bank | input | BANK_W (3) | Target bank of the proposal |
| cmd_allowed | output | 1 | The proposal meets every timing and bank-state rule this cycle |
| refresh_req | output | 1 | A refresh is due |

## Verification
The bench uses the default parameters: eight banks and a 32-bit word. The reset refresh interval of 1038 cycles is short enough to be reached and timed exactly. After that the bench programs small row fields (rfc 4, rrd 2, rp 3, rcd 2, rc 5, ras 3), which puts every spacing rule within a few cycles. Each rule can then be shown one cycle too early and right on time inside a single vector walk. A later reprogramming uses zero fields together with an rc larger than ras plus rp, so that the same-bank activate rule is the only rule blocking at its boundary. The reset rfc of 15 is kept running across a write of 4, which shows that a write does not cut short a countdown already in progress.

// File: rtl/dtg_pkg.sv
// Package: shared command codes, timing-word layout and reset values for
// the DRAM command timing gate. The row-word field order is fixed because
// software packs the word with these bit positions.
package dtg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    localparam int REFI_W = 16;
    localparam int RFC_W  = 8;
    localparam int RRD_W  = 4;
    localparam int RP_W   = 4;
    localparam int RCD_W  = 4;
    localparam int RC_W   = 6;
    localparam int RAS_W  = 6;

    // Packed most-significant first: rfc occupies the top byte.
    typedef struct packed {
        logic [RFC_W-1:0] rfc;
        logic [RRD_W-1:0] rrd;
        logic [RP_W-1:0]  rp;
        logic [RCD_W-1:0] rcd;
        logic [RC_W-1:0]  rc;
        logic [RAS_W-1:0] ras;
    } row_t;

    localparam int ROW_W = $bits(row_t);

    localparam logic [REFI_W-1:0] REFI_RST = 16'h040E;
    localparam row_t ROW_RST = '{rfc: 8'h0F, rrd: 4'h2, rp: 4'h3,
                                 rcd: 4'h3, rc: 6'h0A, ras: 6'h06};

endpackage

// File: rtl/dtg_regs.sv
// Module: holds the refresh-interval word and the row-timing word.
// Assumes DW >= ROW_W and DW > REFI_W. Reserved bits of the interval word
// are not stored and read back as zero.
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [REFI_W-1:0] refi_q,
    output row_t              row_q
);

    localparam int RSV_W = DW - REFI_W;

    // Load reset values or accept a write to the picked word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refi_q <= REFI_RST;
            row_q  <= ROW_RST;
        end else if (we) begin
            if (sel) row_q  <= row_t'(wdata[ROW_W-1:0]);
            else     refi_q <= wdata[REFI_W-1:0];
        end
    end

    // Read mux; the reserved interval bits are tied to zero.
    always_comb begin
        rdata = sel ? DW'(row_q) : {{RSV_W{1'b0}}, refi_q};
    end

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata[DW-1:REFI_W] == '0));

endmodule

// File: rtl/dtg_down_timer.sv
// Module: one spacing countdown. A load at an issue edge stores the spacing
// value. The timer reports done once that many cycles have passed since the
// issue. A stored value of 0 or 1 means done on the next cycle.
module dtg_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Count down to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q <= W'(1));

    p_load_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && val > W'(1)) |=> !done);

endmodule

// File: rtl/dtg_bank.sv
// Module: open/closed state and the four per-bank spacing timers of one bank.
// Assumes at most one command issues per cycle, so act_hit and pre_hit
// are never high together.
module dtg_bank
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_hit,
    input  logic pre_hit,
    input  row_t tim,
    output logic is_open,
    output logic act_ok,
    output logic col_ok,
    output logic pre_ok
);

    logic open_q;
    logic rcd_done, ras_done, rc_done, rp_done;

    // Track whether the bank holds an open row.
    always_ff @(posedge clk) begin
        if (!rst_n)       open_q <= 1'b0;
        else if (act_hit) open_q <= 1'b1;
        else if (pre_hit) open_q <= 1'b0;
    end

    dtg_down_timer #(.W(RCD_W)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_hit),
                                       .val(tim.rcd), .done(rcd_done));
    dtg_down_timer #(.W(RAS_W)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_hit),
                                       .val(tim.ras), .done(ras_done));
    dtg_down_timer #(.W(RC_W))  u_rc  (.clk(clk), .rst_n(rst_n), .load(act_hit),
                                       .val(tim.rc),  .done(rc_done));
    dtg_down_timer #(.W(RP_W))  u_rp  (.clk(clk), .rst_n(rst_n), .load(pre_hit),
                                       .val(tim.rp),  .done(rp_done));

    assign is_open = open_q;
    assign act_ok  = !open_q && rc_done && rp_done;
    assign col_ok  = open_q && rcd_done;
    assign pre_ok  = open_q && ras_done;

    p_open_on_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> is_open);
    p_close_on_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_hit |=> !is_open);
    p_rcd_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && tim.rcd > 4'd1) |=> !col_ok);
    p_ras_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && tim.ras > 6'd1) |=> !pre_ok);
    p_rp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && tim.rp > 4'd1) |=> !act_ok);

endmodule

// File: rtl/dtg_refresh.sv
// Module: refresh-interval scheduler. The counter reloads on each issued
// refresh and holds at zero, which keeps the request up until the next
// refresh issues. An interval of zero counts as one cycle.
module dtg_refresh #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = 16'h040E
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] refi,
    input  logic         ref_hit,
    output logic         ref_req
);

    localparam logic [W-1:0] RST_LOAD = (RST_VAL == '0) ? W'(1) : RST_VAL;

    logic [W-1:0] cnt_q;
    logic [W-1:0] reload;

    assign reload = (refi == '0) ? W'(1) : refi;

    // Interval countdown, restarted by each issued refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= RST_LOAD;
        else if (ref_hit)      cnt_q <= reload;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign ref_req = (cnt_q == '0);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_hit) |=> ref_req);
    p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hit |=> !ref_req);

endmodule

// File: rtl/dram_cmd_timing_gate.sv
// Module: top of the DRAM command timing gate. It combines the per-bank
// rules with the inter-bank activate spacing, the refresh lockout and the
// refresh scheduler, and reports whether the proposal may issue this cycle.
// Assumes NUM_BANKS is a power of two, so every prop_bank value names a bank.
module dram_cmd_timing_gate
    import dtg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int DW        = 32,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              prop_valid,
    input  logic [2:0]        prop_cmd,
    input  logic [BANK_W-1:0] prop_bank,
    output logic              cmd_allowed,
    output logic              refresh_req
);

    logic [REFI_W-1:0]    refi_q;
    row_t                 row_q;
    cmd_e                 cmd;
    logic                 issue, act_issue, pre_issue, ref_issue;
    logic                 rrd_done, rfc_done, rrd_clear, all_closed;
    logic [BANK_W-1:0]    last_act_q;
    logic [NUM_BANKS-1:0] open_vec, act_ok_vec, col_ok_vec, pre_ok_vec;

    dtg_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .refi_q(refi_q), .row_q(row_q)
    );

    assign cmd       = cmd_e'(prop_cmd);
    assign issue     = prop_valid && cmd_allowed;
    assign act_issue = issue && (cmd == CMD_ACT);
    assign pre_issue = issue && (cmd == CMD_PRE);
    assign ref_issue = issue && (cmd == CMD_REF);

    // One bank slice per bank; the slice whose index matches takes the hit.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_b;
        assign sel_b = (prop_bank == BANK_W'(b));
        dtg_bank u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_hit(act_issue && sel_b), .pre_hit(pre_issue && sel_b),
            .tim(row_q), .is_open(open_vec[b]), .act_ok(act_ok_vec[b]),
            .col_ok(col_ok_vec[b]), .pre_ok(pre_ok_vec[b])
        );
    end

    dtg_down_timer #(.W(RRD_W)) u_rrd (.clk(clk), .rst_n(rst_n), .load(act_issue),
                                       .val(row_q.rrd), .done(rrd_done));
    dtg_down_timer #(.W(RFC_W)) u_rfc (.clk(clk), .rst_n(rst_n), .load(ref_issue),
                                       .val(row_q.rfc), .done(rfc_done));

    // Remember the bank of the most recent activate for the cross-bank rule.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_act_q <= '0;
        else if (act_issue) last_act_q <= prop_bank;
    end

    assign rrd_clear  = rrd_done || (prop_bank == last_act_q);
    assign all_closed = (open_vec == '0);

    // Combine the rules that apply to the proposed command.
    always_comb begin
        cmd_allowed = 1'b0;
        case (cmd)
            CMD_ACT:        cmd_allowed = act_ok_vec[prop_bank] && rrd_clear && rfc_done;
            CMD_RD, CMD_WR: cmd_allowed = col_ok_vec[prop_bank];
            CMD_PRE:        cmd_allowed = pre_ok_vec[prop_bank];
            CMD_REF:        cmd_allowed = all_closed && rfc_done;
            default:        cmd_allowed = 1'b0;
        endcase
    end

    dtg_refresh #(.W(REFI_W), .RST_VAL(REFI_RST)) u_refresh (
        .clk(clk), .rst_n(rst_n), .refi(refi_q),
        .ref_hit(ref_issue), .ref_req(refresh_req)
    );

    p_ref_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_issue |=> (open_vec == '0));
    p_rfc_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_issue && row_q.rfc > 8'd1) |=> !rfc_done);
    p_rrd_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_issue && row_q.rrd > 4'd1) |=> !rrd_done);
    p_nop_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_cmd == 3'd0) |-> !cmd_allowed);

endmodule

// File: tb/dram_cmd_timing_gate_tb.sv
`timescale 1ns/1ps
module dram_cmd_timing_gate_tb;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_WR = 3'd3, C_PRE = 3'd4, C_REF = 3'd5;

    typedef struct packed {
        logic [2:0] cmd;
        logic [2:0] bank;
        logic       ok;
        logic [7:0] req;
    } vec_t;

    // Walk with row word 0x04232143: rfc 4, rrd 2, rp 3, rcd 2, rc 5, ras 3.
    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{C_ACT, 3'd0, 1'b1, 8'd5},   //  0 R5 closed bank opens
        '{C_ACT, 3'd1, 1'b0, 8'd9},   //  1 R9 one cycle early
        '{C_ACT, 3'd1, 1'b1, 8'd9},   //  2 R9 on time
        '{C_RD,  3'd1, 1'b0, 8'd6},   //  3 R6 early
        '{C_RD,  3'd0, 1'b1, 8'd6},   //  4 R6
        '{C_WR,  3'd1, 1'b1, 8'd6},   //  5 R6 on time
        '{C_PRE, 3'd2, 1'b0, 8'd5},   //  6 R5 closed bank
        '{C_RD,  3'd2, 1'b0, 8'd5},   //  7 R5 closed bank
        '{C_ACT, 3'd0, 1'b0, 8'd5},   //  8 R5 open bank
        '{C_PRE, 3'd0, 1'b1, 8'd7},   //  9 R7
        '{C_ACT, 3'd0, 1'b0, 8'd8},   // 10 R8 early
        '{C_REF, 3'd0, 1'b0, 8'd10},  // 11 R10 bank 1 open
        '{C_ACT, 3'd0, 1'b1, 8'd8},   // 12 R8 on time
        '{C_ACT, 3'd3, 1'b0, 8'd9},   // 13 R9 early
        '{C_PRE, 3'd0, 1'b0, 8'd7},   // 14 R7 ras early
        '{C_PRE, 3'd0, 1'b1, 8'd7},   // 15 R7 ras on time
        '{C_PRE, 3'd1, 1'b1, 8'd5},   // 16 R5
        '{C_REF, 3'd0, 1'b1, 8'd10},  // 17 R10 all closed
        '{C_ACT, 3'd0, 1'b0, 8'd10},  // 18 R10 rfc lockout
        '{C_REF, 3'd0, 1'b0, 8'd10},  // 19 R10 rfc lockout
        '{C_ACT, 3'd5, 1'b0, 8'd10},  // 20 R10 early
        '{C_ACT, 3'd5, 1'b1, 8'd10},  // 21 R10 on time
        '{C_RD,  3'd5, 1'b0, 8'd6},   // 22 R6 early
        '{C_RD,  3'd5, 1'b1, 8'd6},   // 23 R6 on time
        '{C_NOP, 3'd5, 1'b0, 8'd12}   // 24 R12 no-op
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        prop_valid = 1'b0;
    logic [2:0]  prop_cmd = 3'd0, prop_bank = 3'd0;
    logic        cmd_allowed, refresh_req;
    int          n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    dram_cmd_timing_gate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prop_valid(prop_valid),
        .prop_cmd(prop_cmd), .prop_bank(prop_bank),
        .cmd_allowed(cmd_allowed), .refresh_req(refresh_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic propose(input logic [2:0] c, input logic [2:0] b,
                           input logic v, input logic exp, input string tag);
        prop_cmd = c; prop_bank = b; prop_valid = v;
        #1;
        chk(tag, {31'd0, cmd_allowed}, {31'd0, exp});
        @(negedge clk);
        prop_valid = 1'b0; prop_cmd = C_NOP;
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_chk(input logic sel, input logic [31:0] exp, input string tag);
        cfg_sel = sel;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic wait_req(inout int n);
        while (!refresh_req && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values and state
        read_chk(1'b0, 32'h0000_040E, "R1 interval word reset");
        read_chk(1'b1, 32'h0F23_3286, "R1 row word reset");
        chk("R3 no request after reset", {31'd0, refresh_req}, 32'd0);
        prop_cmd = C_ACT; prop_bank = 3'd0; #1;
        chk("R5 closed bank may activate", {31'd0, cmd_allowed}, 32'd1);
        prop_cmd = 3'd7; #1;
        chk("R12 code 7 not allowed", {31'd0, cmd_allowed}, 32'd0);
        prop_cmd = C_NOP;

        // R2 reset interval of 1038 edges
        n = 0;
        wait_req(n);
        chk("R2 reset interval edges", n, 32'd1038);
        repeat (5) @(negedge clk);
        chk("R3 request held", {31'd0, refresh_req}, 32'd1);

        // Refresh with reset rfc 15, then reprogram rfc to 4 mid-countdown.
        propose(C_REF, 3'd0, 1'b1, 1'b1, "R10 refresh all closed");
        chk("R3 request drops after refresh", {31'd0, refresh_req}, 32'd0);
        cfg_write(1'b1, 32'h0423_2143);
        repeat (12) @(negedge clk);
        propose(C_ACT, 3'd0, 1'b0, 1'b0, "R4 old rfc still runs");
        propose(C_ACT, 3'd0, 1'b0, 1'b1, "R4 old rfc expires");

        // Interval reprogramming: 20 for the next countdown, 5 written mid-way.
        cfg_write(1'b0, 32'd20);
        propose(C_REF, 3'd0, 1'b1, 1'b1, "R10 refresh");
        n = 0;
        cfg_write(1'b0, 32'd5);
        n = 1;
        wait_req(n);
        chk("R4 interval write mid countdown", n, 32'd20);
        propose(C_REF, 3'd0, 1'b1, 1'b1, "R10 refresh");
        n = 0;
        wait_req(n);
        chk("R2 new interval edges", n, 32'd5);

        // Vector walk through the spacing rules.
        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d vector %0d", VEC[i].req, i);
            propose(VEC[i].cmd, VEC[i].bank, 1'b1, VEC[i].ok, t);
        end

        // Zero fields and a binding same-bank rule: rc 6, ras 2, rest 0.
        cfg_write(1'b1, 32'h0000_0182);
        read_chk(1'b1, 32'h0000_0182, "R1 row word readback");
        propose(C_PRE, 3'd5, 1'b1, 1'b1, "R5 close bank 5");
        propose(C_ACT, 3'd5, 1'b1, 1'b1, "R11 zero rp one cycle");
        propose(C_RD,  3'd5, 1'b1, 1'b1, "R11 zero rcd one cycle");
        propose(C_PRE, 3'd5, 1'b1, 1'b1, "R7 ras of 2");
        propose(C_ACT, 3'd5, 1'b1, 1'b0, "R7 rc blocks");
        propose(C_ACT, 3'd5, 1'b1, 1'b0, "R7 rc blocks");
        propose(C_ACT, 3'd6, 1'b1, 1'b1, "R9 other bank");
        propose(C_ACT, 3'd5, 1'b1, 1'b1, "R7 rc on time");

        // R1 reserved interval bits read as zero.
        cfg_write(1'b0, 32'hABCD_0007);
        read_chk(1'b0, 32'h0000_0007, "R1 reserved bits zero");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule